// File: doc/BRIEF.md
# Interrupt Line Enable, Pending and Priority Register Bank

This block holds the software-visible state of a small nested interrupt controller that serves up to 32 interrupt lines. For each line it keeps an enable flag, a pending flag and a priority level. It presents all three continuously to the arbitration logic downstream, which picks the winning line. Software reaches the state through a simple 32-bit word bus slave. Enable and pending each have two write addresses: one where a 1 in the data sets the matching flag, and one where a 1 clears it. Writing a 0 to either address leaves the flag alone, so software never needs a read-modify-write to change a single line.

Request inputs are level signals. Every cycle a request is high, it forces the pending flag of its line on. A software clear therefore only takes effect once the source has let go of its request. Priorities are packed four lines to a 32-bit word. Only the upper bits of each byte hold storage, so the level steps are coarse.

The bus port is always ready. It takes one read or one write in any cycle and never stalls, so no back-pressure exists. Write effects show on the state outputs one clock after the write. Read data appears on `bus_rdata` one clock after the read and holds until the next read. The enable, pending and priority outputs are plain level outputs with no handshake.

Top module: `irq_regbank`

## Requirements
- R1: A write to byte offset 0x100 sets the enable flag of every line whose data bit is 1. Lines whose data bit is 0 keep their enable flag.
- R2: A write to byte offset 0x180 clears the enable flag of every line whose data bit is 1. Lines whose data bit is 0 keep their enable flag.
- R3: Byte offset 0x200 sets pending flags and byte offset 0x280 clears them. Both use the same write-one rule as R1 and R2.
- R4: A read of 0x100 or 0x180 returns the enable vector, with line n in bit n. A read of 0x200 or 0x280 returns the pending vector in the same layout. Bits at and above NUM_LINES read 0.
- R5: Priority words start at byte offset 0x400, one word per four lines. Line n is in word n/4 (at offset 0x400 + 4*(n/4)), in bits 8*(n%4)+7 down to 8*(n%4). A write replaces all four bytes of the addressed word and leaves every other word unchanged.
- R6: Only the top PRIO_BITS bits of each priority byte are stored (2 by default, giving levels 0x00, 0x40, 0x80 and 0xC0). The lower bits always read as 0, both on the bus and on `line_prio`.
- R7: A request that is high in a cycle makes its pending flag read 1 from the next clock. This holds even when a clear-pending write hits the same line in the same cycle.
- R8: A pending flag stays set after its request drops, until software clears it.
- R9: A word address that maps to no register reads as 0 and ignores writes. Byte address bits 1:0 are ignored. Priority words at or beyond (NUM_LINES+3)/4 are unmapped.
- R10: Reset (active-low, asynchronous) clears all enable, pending and priority state, and clears `bus_rdata`.
- R11: Read data appears on `bus_rdata` at the clock after `bus_re` is sampled high and holds until the next read.
- R12: `line_enable`, `line_pending` and `line_prio` reflect a write at the clock edge that samples it. Without a write to an enable address, the enable vector does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_req | input | NUM_LINES | Level interrupt requests, one per line |
| line_enable | output | NUM_LINES | Enable flag per line |
| line_pending | output | NUM_LINES | Pending flag per line |
| line_prio | output | 8*NUM_LINES | Priority byte per line, line n in bits 8n+7:8n |

## Verification
The bench builds the block with NUM_LINES = 20 and PRIO_BITS = 2. Twenty lines leave bits 31:20 of the enable and pending words unbacked. This shows that set-all writes cannot create phantom lines there. It also needs only five priority words, so the word at 0x414, inside the priority window, has to behave as unmapped. With two priority bits, the bench can write all-ones bytes and confirm that the six lower bits read back as zero. The scoreboard also exercises the race between a request and a same-cycle clear, and a request held high through a clear.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;

  localparam int ADDR_W = 12;
  localparam int WORD_W = ADDR_W - 2;

  // word addresses (byte offset / 4)
  localparam logic [WORD_W-1:0] W_SET_EN = 10'h040;
  localparam logic [WORD_W-1:0] W_CLR_EN = 10'h060;
  localparam logic [WORD_W-1:0] W_SET_PD = 10'h080;
  localparam logic [WORD_W-1:0] W_CLR_PD = 10'h0A0;
  localparam logic [WORD_W-1:0] W_PRIO   = 10'h100;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_ENABLE,
    RS_PENDING,
    RS_PRIO
  } rsel_e;

  typedef struct packed {
    logic set_en;
    logic clr_en;
    logic set_pd;
    logic clr_pd;
    logic prio;
  } wr_strb_t;

endpackage

// File: rtl/irq_regbank_decode.sv
module irq_regbank_decode
  import irq_regbank_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output wr_strb_t          strb,
  output rsel_e             rsel,
  output logic [IDX_W-1:0]  prio_idx
);

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] prio_off;
  logic              prio_hit;
  logic [1:0]        unused_lsb;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];
  assign prio_off   = word - W_PRIO;
  assign prio_hit   = (word >= W_PRIO) && (prio_off < WORD_W'(NUM_REGS));
  assign prio_idx   = IDX_W'(prio_off);

  always_comb begin
    if (word == W_SET_EN || word == W_CLR_EN)      rsel = RS_ENABLE;
    else if (word == W_SET_PD || word == W_CLR_PD) rsel = RS_PENDING;
    else if (prio_hit)                             rsel = RS_PRIO;
    else                                           rsel = RS_NONE;
  end

  always_comb begin
    strb        = '0;
    strb.set_en = we && (word == W_SET_EN);
    strb.clr_en = we && (word == W_CLR_EN);
    strb.set_pd = we && (word == W_SET_PD);
    strb.clr_pd = we && (word == W_CLR_PD);
    strb.prio   = we && prio_hit;
  end

endmodule

// File: rtl/irq_regbank_flags.sv
module irq_regbank_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] force_set,
  output logic [W-1:0] q
);

  // Software set/clear first, then a level source overrides the clear.
  logic [W-1:0] q_next;

  always_comb q_next = ((q | set_mask) & ~clr_mask) | force_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/irq_regbank_prio.sv
module irq_regbank_prio #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 2,
  parameter int NUM_REGS  = 8,
  parameter int IDX_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            wdata,
  output logic [8*NUM_LINES-1:0] prio_flat,
  output logic [31:0]            rd_word
);

  logic [PRIO_BITS-1:0] lvl [NUM_LINES];
  logic [31:0]          reg_words [NUM_REGS];
  logic                 unused_bits;

  assign unused_bits = ^wdata;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam int REG_I = n / 4;
    localparam int LANE  = n % 4;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl[n] <= '0;
      else if (we && idx == IDX_W'(REG_I))
        lvl[n] <= wdata[8*LANE+7 -: PRIO_BITS];
    end

    assign prio_flat[8*n +: 8] = 8'(lvl[n]) << (8 - PRIO_BITS);
  end

  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) reg_words[r] = '0;
    for (int n = 0; n < NUM_LINES; n++)
      reg_words[n/4][8*(n%4) +: 8] = prio_flat[8*n +: 8];
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (idx == IDX_W'(r)) rd_word = reg_words[r];
  end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_regbank_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  input  logic                   bus_we,
  input  logic                   bus_re,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_LINES-1:0]   irq_req,
  output logic [NUM_LINES-1:0]   line_enable,
  output logic [NUM_LINES-1:0]   line_pending,
  output logic [8*NUM_LINES-1:0] line_prio
);

  localparam int NUM_REGS = (NUM_LINES + 3) / 4;
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  wr_strb_t             strb;
  rsel_e                rsel;
  logic [IDX_W-1:0]     prio_idx;
  logic [NUM_LINES-1:0] wd_lines;
  logic [31:0]          prio_word;
  logic [31:0]          rd_next;

  assign wd_lines = bus_wdata[NUM_LINES-1:0];

  irq_regbank_decode #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_decode (
    .addr     (bus_addr),
    .we       (bus_we),
    .strb     (strb),
    .rsel     (rsel),
    .prio_idx (prio_idx)
  );

  irq_regbank_flags #(.W(NUM_LINES)) u_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_mask  (strb.set_en ? wd_lines : '0),
    .clr_mask  (strb.clr_en ? wd_lines : '0),
    .force_set ('0),
    .q         (line_enable)
  );

  irq_regbank_flags #(.W(NUM_LINES)) u_pending (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_mask  (strb.set_pd ? wd_lines : '0),
    .clr_mask  (strb.clr_pd ? wd_lines : '0),
    .force_set (irq_req),
    .q         (line_pending)
  );

  irq_regbank_prio #(
    .NUM_LINES (NUM_LINES),
    .PRIO_BITS (PRIO_BITS),
    .NUM_REGS  (NUM_REGS),
    .IDX_W     (IDX_W)
  ) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (strb.prio),
    .idx       (prio_idx),
    .wdata     (bus_wdata),
    .prio_flat (line_prio),
    .rd_word   (prio_word)
  );

  always_comb begin
    case (rsel)
      RS_ENABLE:  rd_next = 32'(line_enable);
      RS_PENDING: rd_next = 32'(line_pending);
      RS_PRIO:    rd_next = prio_word;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end

endmodule

// File: rtl/irq_regbank_checks.sv
module irq_regbank_checks
  import irq_regbank_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int PRIO_BITS = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [31:0]            bus_wdata,
  input logic                   bus_we,
  input logic                   bus_re,
  input logic [31:0]            bus_rdata,
  input logic [NUM_LINES-1:0]   irq_req,
  input logic [NUM_LINES-1:0]   line_enable,
  input logic [NUM_LINES-1:0]   line_pending,
  input logic [8*NUM_LINES-1:0] line_prio
);

  localparam int NUM_REGS = (NUM_LINES + 3) / 4;

  function automatic logic [8*NUM_LINES-1:0] low_mask();
    logic [8*NUM_LINES-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_LINES; n++) m[8*n +: 8] = 8'hFF >> PRIO_BITS;
    return m;
  endfunction

  localparam logic [8*NUM_LINES-1:0] LOW_MASK = low_mask();

  logic [WORD_W-1:0]    word;
  logic [NUM_LINES-1:0] wd;
  logic                 unmapped;
  logic                 unused_chk;

  assign word       = bus_addr[ADDR_W-1:2];
  assign wd         = bus_wdata[NUM_LINES-1:0];
  assign unused_chk = ^{bus_addr[1:0], bus_wdata};
  assign unmapped   = !(word == W_SET_EN || word == W_CLR_EN ||
                        word == W_SET_PD || word == W_CLR_PD) &&
                      !(word >= W_PRIO && word < W_PRIO + WORD_W'(NUM_REGS));

  assert_set_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == W_SET_EN) |=> ((line_enable & $past(wd)) == $past(wd)));

  assert_clear_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == W_CLR_EN) |=> ((line_enable & $past(wd)) == '0));

  assert_clear_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && word == W_CLR_PD) |=> ((line_pending & $past(wd) & ~$past(irq_req)) == '0));

  assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_prio & LOW_MASK) == '0);

  assert_request_pends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((line_pending & $past(irq_req)) == $past(irq_req)));

  assert_pending_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && word == W_CLR_PD) |=>
      ((line_pending & $past(line_pending)) == $past(line_pending)));

  assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && unmapped) |=> (bus_rdata == '0));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  assert_enable_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (word == W_SET_EN || word == W_CLR_EN)) |=> $stable(line_enable));

endmodule

bind irq_regbank irq_regbank_checks #(
  .NUM_LINES (NUM_LINES),
  .PRIO_BITS (PRIO_BITS)
) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_we       (bus_we),
  .bus_re       (bus_re),
  .bus_rdata    (bus_rdata),
  .irq_req      (irq_req),
  .line_enable  (line_enable),
  .line_pending (line_pending),
  .line_prio    (line_prio)
);

// File: tb/irq_regbank_bench.sv
module irq_regbank_bench;

  localparam int NL = 20;
  localparam logic [31:0] LMASK = 32'h000F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_req = '0;
  logic [NL-1:0] line_enable;
  logic [NL-1:0] line_pending;
  logic [8*NL-1:0] line_prio;

  int n_chk = 0;
  int n_fail = 0;
  logic re_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  irq_regbank #(.NUM_LINES(NL), .PRIO_BITS(2)) u_irq_regbank (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_we (bus_we), .bus_re (bus_re), .bus_rdata (bus_rdata), .irq_req (irq_req),
    .line_enable (line_enable), .line_pending (line_pending), .line_prio (line_prio)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) re_seen <= bus_re;
  always @(negedge clk) begin
    if (re_seen) begin
      if (exp_q.size() == 0) begin
        chk("R11 read with empty scoreboard", bus_rdata, 32'hDEAD_BEEF);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset enable", 32'(line_enable), 32'h0);
    chk("R10 reset pending", 32'(line_pending), 32'h0);
    chk("R10 reset prio", 32'(|line_prio), 32'h0);
    rst_n = 1'b1;
    rd(12'h100, 32'h0, "R10 enable reads zero after reset");

    // R1: set enable, bits above NL discarded
    wr(12'h100, 32'hFFFF_F00F);
    chk("R1 set enable", 32'(line_enable), 32'hFFFF_F00F & LMASK);
    rd(12'h100, 32'h000F_F00F, "R4 read set-enable alias");
    rd(12'h180, 32'h000F_F00F, "R4 read clear-enable alias");

    // R2: clear enable
    wr(12'h180, 32'h0000_0103);
    chk("R2 clear enable", 32'(line_enable), 32'h000F_F00C);
    wr(12'h100, 32'h0);
    chk("R1 zero write keeps enable", 32'(line_enable), 32'h000F_F00C);
    wr(12'h180, 32'h0);
    chk("R2 zero write keeps enable", 32'(line_enable), 32'h000F_F00C);

    // R3: pending set/clear
    wr(12'h200, 32'h0000_0011);
    chk("R3 set pending", 32'(line_pending), 32'h11);
    wr(12'h280, 32'h0000_0001);
    chk("R3 clear pending", 32'(line_pending), 32'h10);
    rd(12'h280, 32'h10, "R4 read clear-pending alias");
    rd(12'h200, 32'h10, "R4 read set-pending alias");

    // R5/R6/R12: priority words
    wr(12'h404, 32'hFFC0_4180);
    chk("R12 line 6 prio after write", 32'(line_prio[55:48]), 32'hC0);
    chk("R6 line 5 prio low bits", 32'(line_prio[47:40]), 32'h40);
    rd(12'h404, 32'hC0C0_4080, "R5 R6 priority word 1");
    wr(12'h410, 32'h3F3F_3F3F);
    rd(12'h410, 32'h0, "R6 low-only bits not stored");
    wr(12'h400, 32'h0000_0040);
    rd(12'h400, 32'h0000_0040, "R5 priority word 0");
    rd(12'h404, 32'hC0C0_4080, "R5 other word untouched");
    chk("R5 line 0 on line_prio", 32'(line_prio[7:0]), 32'h40);

    // R9: unmapped, low address bits
    wr(12'h414, 32'hFFFF_FFFF);
    rd(12'h414, 32'h0, "R9 priority word beyond lines");
    wr(12'h300, 32'hFFFF_FFFF);
    chk("R9 unmapped write keeps enable", 32'(line_enable), 32'h000F_F00C);
    chk("R9 unmapped write keeps pending", 32'(line_pending), 32'h10);
    rd(12'h300, 32'h0, "R9 unmapped read");
    rd(12'h102, 32'h000F_F00C, "R9 byte address bits ignored");

    // R7: request beats same-cycle clear
    @(negedge clk);
    irq_req[5] = 1'b1;
    bus_we = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h20;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R7 request wins over clear", 32'(line_pending), 32'h30);
    wr(12'h280, 32'h20);
    chk("R7 held request re-pends", 32'(line_pending), 32'h30);
    rd(12'h280, 32'h30, "R7 held request reads pending");
    irq_req[5] = 1'b0;
    wr(12'h280, 32'h20);
    chk("R7 clear after release", 32'(line_pending), 32'h10);

    // R8: pulse latches
    @(negedge clk); irq_req[7] = 1'b1;
    @(negedge clk); irq_req[7] = 1'b0;
    chk("R8 pulse pends", 32'(line_pending), 32'h90);
    repeat (3) @(negedge clk);
    chk("R8 pending latched", 32'(line_pending), 32'h90);

    // R11: hold
    rd(12'h200, 32'h90, "R11 read pending");
    @(negedge clk);
    @(negedge clk);
    chk("R11 rdata holds", bus_rdata, 32'h90);

    // R10: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears enable", 32'(line_enable), 32'h0);
    chk("R10 reset clears pending", 32'(line_pending), 32'h0);
    chk("R10 reset clears prio", 32'(|line_prio), 32'h0);
    chk("R10 reset clears rdata", bus_rdata, 32'h0);
    rst_n = 1'b1;
    rd(12'h404, 32'h0, "R10 priority cleared by reset");
    repeat (2) @(negedge clk);
    chk("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule